// File: doc/BRIEF.md
# EPP Write-Cycle Controller

This block is the host-side engine for Enhanced Parallel Port address and data writes. A system-bus write request (`wr_req` held high, `wr_sel_addr` choosing the address or data register, `wr_data` carrying the byte) starts a cycle. The block stalls the system bus by pulling `host_rdy` low, then runs the interlocked handshake with the peripheral. It waits for the peripheral's active-low wait line to go low. It then drives the byte, selects output direction and asserts the active-low write line, and pulses the matching strobe. It waits for the wait line to rise again, ends the strobe, drops the write line and finally lets the system bus go.

The peripheral's wait line passes through a configurable synchronizer before the sequencer sees it. A cycle counter bounds the time from the start of a cycle to the peripheral's acknowledge. If that time runs out, the cycle is abandoned and a sticky timeout flag is raised; software clears the flag with a pulse on `tmo_clr`. The control-port bits also act on the cycle. A set strobe bit forces write direction for the whole cycle. A set direction bit turns the write into a harmless read-looking handshake. Outside a cycle the pins simply follow the control and data registers of the standard port.

Top module: `epp_wr_engine`

## Requirements
- R1: `host_rdy` is low in the same cycle in which an idle block sees `wr_req` high. It stays low until the cycle completes or is aborted, and while a strobe is active it is never high.
- R2: If `dev_wait_n` is high when a cycle starts, neither strobe falls and `pwr_n` stays high until `dev_wait_n` has been low for the synchronizer delay. With two synchronizer stages, a low driven before the request gives a strobe 3 clocks after the request. A low driven k clocks after the request gives a strobe k+4 clocks after the request.
- R3: `wr_sel_addr`=1 pulses `astb_n` and `wr_sel_addr`=0 pulses `dstb_n`, never both at once. While the strobe is low, `pbus_q` holds the requested byte unchanged, `pbus_oe` is 1 and `pwr_n` is 0 (with `ctl_dir`=0).
- R4: The strobe stays low until `dev_wait_n` is seen high, and rises 3 clocks after `dev_wait_n` rises. `pwr_n` rises one clock after the strobe, and `host_rdy` rises one clock after that.
- R5: If a cycle has not reached the acknowledge within `TMO_CYC` clocks of its start, it is aborted `TMO_CYC`+1 clocks after the request. At that point both strobes are high and `host_rdy` is high. This applies whether the block is stuck before the strobe or during it.
- R6: `tmo_flag` is set by an abort and stays set until a `tmo_clr` pulse; it reads 0 one clock after the pulse. A normal cycle never sets it.
- R7: While a cycle is in progress and `ctl_strobe` is 1, `pbus_oe` is 1 and `pwr_n` is 0, even with `ctl_dir`=1.
- R8: With `ctl_dir`=1 and `ctl_strobe`=0, a requested write keeps `pbus_oe`=0 and `pwr_n`=1 throughout, still pulses the selected strobe with normal timing, and does not set `tmo_flag`.
- R9: When idle, `lp_strobe`, `lp_feed` and `lp_init` equal `ctl_strobe`, `ctl_feed` and `ctl_init`. In the same state `pbus_q` equals `spp_dat`, `pbus_oe` equals the inverse of `ctl_dir`, and `pwr_n`, `astb_n` and `dstb_n` are high.
- R10: After a cycle ends, holding `wr_req` high starts no further cycle: `host_rdy` stays high and both strobes stay high until `wr_req` has been low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | System-bus write request, held for the whole bus cycle |
| wr_sel_addr | input | 1 | 1 selects address write, 0 selects data write |
| wr_data | input | DW | Byte to transfer |
| tmo_clr | input | 1 | Clears the timeout flag |
| tmo_flag | output | 1 | Sticky timeout indication |
| host_rdy | output | 1 | System-bus ready; low stalls the host |
| ctl_strobe | input | 1 | Control-port strobe bit |
| ctl_feed | input | 1 | Control-port auto-feed bit |
| ctl_init | input | 1 | Control-port initialise bit |
| ctl_dir | input | 1 | Control-port direction bit, 1 = input |
| spp_dat | input | DW | Standard-port data register |
| dev_wait_n | input | 1 | Peripheral wait, active low (asynchronous) |
| pbus_q | output | DW | Parallel data bus output value |
| pbus_oe | output | 1 | Parallel data bus output enable |
| pwr_n | output | 1 | Write indication to peripheral, active low |
| dstb_n | output | 1 | Data strobe, active low |
| astb_n | output | 1 | Address strobe, active low |
| lp_strobe | output | 1 | Strobe line from the control port |
| lp_feed | output | 1 | Auto-feed line from the control port |
| lp_init | output | 1 | Initialise line from the control port |

## Verification
The bench builds the block with `DW`=8, `SYNC_STAGES`=2 and `TMO_CYC`=16. The 8-bit width lets every byte value pass through both the address and the data strobe. The short 16-clock limit makes a hung cycle, stuck either before or during the strobe, cost only a few dozen clocks, so its exact abort cycle can be checked directly. With two synchronizer stages the latencies from the wait line to the strobe are small fixed numbers. The bench computes them, and sweeps the wait line both already low and going low late, together with zero or one clock of acknowledge delay.

// File: rtl/epp_wr_pkg.sv
package epp_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARM   = 3'd1,
        ST_SETUP = 3'd2,
        ST_STRB  = 3'd3,
        ST_END1  = 3'd4,
        ST_END2  = 3'd5,
        ST_DONE  = 3'd6
    } wr_state_e;

    typedef struct packed {
        logic busy;      // any state but idle
        logic hold;      // host must be stalled
        logic wr_phase;  // write line may be asserted
        logic dstb_n;
        logic astb_n;
    } pin_ctl_t;

    function automatic pin_ctl_t decode_state(input wr_state_e s, input logic sel_addr,
                                              input logic req);
        pin_ctl_t c;
        c.busy     = (s != ST_IDLE);
        c.hold     = (s == ST_IDLE) ? req : (s != ST_DONE);
        c.wr_phase = (s == ST_SETUP) || (s == ST_STRB) || (s == ST_END1);
        c.dstb_n   = !((s == ST_STRB) && !sel_addr);
        c.astb_n   = !((s == ST_STRB) && sel_addr);
        return c;
    endfunction

    function automatic logic in_watch(input wr_state_e s);
        return (s == ST_ARM) || (s == ST_SETUP) || (s == ST_STRB);
    endfunction

endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sh[0] <= RST_VAL;
                else     sh[0] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) sh[i] <= RST_VAL;
                else     sh[i] <= sh[i-1];
            end
        end
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/epp_wdog.sv
module epp_wdog #(
    parameter int TMO_CYC = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int CW = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)   cnt <= '0;
        else if (!expire)  cnt <= cnt + 1'b1;
    end

    assign expire = run && (cnt == LAST);
endmodule

// File: rtl/epp_wr_fsm.sv
module epp_wr_fsm
    import epp_wr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          wr_sel_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          wait_s,
    input  logic          expire,
    input  logic          tmo_clr,
    output wr_state_e     st,
    output logic [DW-1:0] lat_data,
    output logic          lat_sel,
    output logic          tmo_flag
);
    wr_state_e nxt;
    logic      abort;

    always_comb begin
        nxt   = st;
        abort = 1'b0;
        unique case (st)
            ST_IDLE:  if (wr_req) nxt = ST_ARM;
            ST_ARM: begin
                if (expire) begin
                    nxt   = ST_DONE;
                    abort = 1'b1;
                end else if (!wait_s) begin
                    nxt = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (expire) begin
                    nxt   = ST_DONE;
                    abort = 1'b1;
                end else begin
                    nxt = ST_STRB;
                end
            end
            ST_STRB: begin
                if (wait_s) begin
                    nxt = ST_END1;
                end else if (expire) begin
                    nxt   = ST_DONE;
                    abort = 1'b1;
                end
            end
            ST_END1:  nxt = ST_END2;
            ST_END2:  nxt = ST_DONE;
            ST_DONE:  if (!wr_req) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            lat_data <= '0;
            lat_sel  <= 1'b0;
            tmo_flag <= 1'b0;
        end else begin
            st <= nxt;
            if (st == ST_IDLE && wr_req) begin
                lat_data <= wr_data;
                lat_sel  <= wr_sel_addr;
            end
            if (abort)        tmo_flag <= 1'b1;
            else if (tmo_clr) tmo_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/epp_pin_mux.sv
module epp_pin_mux
    import epp_wr_pkg::*;
#(
    parameter int DW = 8
) (
    input  wr_state_e     st,
    input  logic          lat_sel,
    input  logic [DW-1:0] lat_data,
    input  logic          wr_req,
    input  logic          ctl_strobe,
    input  logic          ctl_feed,
    input  logic          ctl_init,
    input  logic          ctl_dir,
    input  logic [DW-1:0] spp_dat,
    output logic          busy,
    output logic          host_rdy,
    output logic [DW-1:0] pbus_q,
    output logic          pbus_oe,
    output logic          pwr_n,
    output logic          dstb_n,
    output logic          astb_n,
    output logic          lp_strobe,
    output logic          lp_feed,
    output logic          lp_init
);
    pin_ctl_t c;
    logic     force_wr;

    always_comb begin
        c        = decode_state(st, lat_sel, wr_req);
        force_wr = c.busy && ctl_strobe;
        busy     = c.busy;
        host_rdy = !c.hold;
        dstb_n   = c.dstb_n;
        astb_n   = c.astb_n;
        pbus_oe  = force_wr || !ctl_dir;
        pwr_n    = !(force_wr || (c.wr_phase && !ctl_dir));
        pbus_q   = c.busy ? lat_data : spp_dat;
        lp_strobe = ctl_strobe;
        lp_feed   = ctl_feed;
        lp_init   = ctl_init;
    end
endmodule

// File: rtl/epp_wr_engine.sv
module epp_wr_engine
    import epp_wr_pkg::*;
#(
    parameter int DW          = 8,
    parameter int TMO_CYC     = 500,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          wr_sel_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          tmo_clr,
    output logic          tmo_flag,
    output logic          host_rdy,
    input  logic          ctl_strobe,
    input  logic          ctl_feed,
    input  logic          ctl_init,
    input  logic          ctl_dir,
    input  logic [DW-1:0] spp_dat,
    input  logic          dev_wait_n,
    output logic [DW-1:0] pbus_q,
    output logic          pbus_oe,
    output logic          pwr_n,
    output logic          dstb_n,
    output logic          astb_n,
    output logic          lp_strobe,
    output logic          lp_feed,
    output logic          lp_init
);
    wr_state_e     st;
    logic          wait_s;
    logic          expire;
    logic [DW-1:0] lat_data;
    logic          lat_sel;
    logic          cyc_busy;

    epp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (dev_wait_n),
        .q   (wait_s)
    );

    epp_wdog #(.TMO_CYC(TMO_CYC)) u_wdog (
        .clk    (clk),
        .rst    (rst),
        .run    (in_watch(st)),
        .expire (expire)
    );

    epp_wr_fsm #(.DW(DW)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .wr_req      (wr_req),
        .wr_sel_addr (wr_sel_addr),
        .wr_data     (wr_data),
        .wait_s      (wait_s),
        .expire      (expire),
        .tmo_clr     (tmo_clr),
        .st          (st),
        .lat_data    (lat_data),
        .lat_sel     (lat_sel),
        .tmo_flag    (tmo_flag)
    );

    epp_pin_mux #(.DW(DW)) u_mux (
        .st         (st),
        .lat_sel    (lat_sel),
        .lat_data   (lat_data),
        .wr_req     (wr_req),
        .ctl_strobe (ctl_strobe),
        .ctl_feed   (ctl_feed),
        .ctl_init   (ctl_init),
        .ctl_dir    (ctl_dir),
        .spp_dat    (spp_dat),
        .busy       (cyc_busy),
        .host_rdy   (host_rdy),
        .pbus_q     (pbus_q),
        .pbus_oe    (pbus_oe),
        .pwr_n      (pwr_n),
        .dstb_n     (dstb_n),
        .astb_n     (astb_n),
        .lp_strobe  (lp_strobe),
        .lp_feed    (lp_feed),
        .lp_init    (lp_init)
    );
endmodule

// File: rtl/epp_wr_engine_chk.sv
module epp_wr_engine_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          host_rdy,
    input logic          dstb_n,
    input logic          astb_n,
    input logic [DW-1:0] pbus_q,
    input logic          pbus_oe,
    input logic          pwr_n,
    input logic          ctl_strobe,
    input logic          ctl_dir,
    input logic          tmo_flag,
    input logic          tmo_clr,
    input logic          cyc_busy
);
    p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        !(!dstb_n && !astb_n));

    p_stall_under_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        (!dstb_n || !astb_n) |-> !host_rdy);

    p_bus_steady_r3: assert property (@(posedge clk) disable iff (rst)
        ((!dstb_n && $past(!dstb_n)) || (!astb_n && $past(!astb_n))) |-> $stable(pbus_q));

    p_abort_release_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_flag) |-> (host_rdy && dstb_n && astb_n));

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (tmo_flag && !tmo_clr) |=> tmo_flag);

    p_force_write_r7: assert property (@(posedge clk) disable iff (rst)
        (cyc_busy && ctl_strobe) |-> (pbus_oe && !pwr_n));

    p_input_dir_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (ctl_dir && !ctl_strobe) |-> (!pbus_oe && pwr_n));
endmodule

bind epp_wr_engine epp_wr_engine_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_rdy   (host_rdy),
    .dstb_n     (dstb_n),
    .astb_n     (astb_n),
    .pbus_q     (pbus_q),
    .pbus_oe    (pbus_oe),
    .pwr_n      (pwr_n),
    .ctl_strobe (ctl_strobe),
    .ctl_dir    (ctl_dir),
    .tmo_flag   (tmo_flag),
    .tmo_clr    (tmo_clr),
    .cyc_busy   (cyc_busy)
);

// File: tb/epp_wr_engine_bench.sv
module epp_wr_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam int TMO        = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_req = 1'b0;
    logic          wr_sel_addr = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          tmo_clr = 1'b0;
    logic          tmo_flag, host_rdy;
    logic          ctl_strobe = 1'b0, ctl_feed = 1'b0, ctl_init = 1'b0, ctl_dir = 1'b0;
    logic [DW-1:0] spp_dat = '0;
    logic          dev_wait_n = 1'b1;
    logic [DW-1:0] pbus_q;
    logic          pbus_oe, pwr_n, dstb_n, astb_n, lp_strobe, lp_feed, lp_init;

    int vectors = 0;
    int fails   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    epp_wr_engine #(.DW(DW), .TMO_CYC(TMO), .SYNC_STAGES(2)) u_epp_wr_engine (
        .clk (clk), .rst (rst), .wr_req (wr_req), .wr_sel_addr (wr_sel_addr),
        .wr_data (wr_data), .tmo_clr (tmo_clr), .tmo_flag (tmo_flag),
        .host_rdy (host_rdy), .ctl_strobe (ctl_strobe), .ctl_feed (ctl_feed),
        .ctl_init (ctl_init), .ctl_dir (ctl_dir), .spp_dat (spp_dat),
        .dev_wait_n (dev_wait_n), .pbus_q (pbus_q), .pbus_oe (pbus_oe),
        .pwr_n (pwr_n), .dstb_n (dstb_n), .astb_n (astb_n),
        .lp_strobe (lp_strobe), .lp_feed (lp_feed), .lp_init (lp_init)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One write cycle with a well-behaved peripheral.
    task automatic do_write(input logic sel, input logic [DW-1:0] d, input bit pre_low,
                            input int ack_dly, input logic exp_oe, input logic exp_wr_n);
        int n;
        int c;
        bit early;
        logic end2_wr_n;
        end2_wr_n = ctl_strobe ? 1'b0 : 1'b1;
        dev_wait_n = pre_low ? 1'b0 : 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 idle ready", {31'd0, host_rdy}, 32'd1);
        wr_sel_addr = sel;
        wr_data     = d;
        wr_req      = 1'b1;
        #1;
        chk("R1 ready drops with request", {31'd0, host_rdy}, 32'd0);
        n = 0;
        early = 0;
        forever begin
            @(negedge clk);
            n++;
            if (!dstb_n || !astb_n || n > 30) break;
            if (!ctl_strobe && pwr_n !== 1'b1 && n < (pre_low ? 2 : 5)) early = 1;
            if (!pre_low && n == 2) dev_wait_n = 1'b0;
        end
        chk("R2 strobe latency", n, pre_low ? 32'd3 : 32'd6);
        chk("R2 no early write line", {31'd0, early}, 32'd0);
        chk("R3 address strobe", {31'd0, astb_n}, {31'd0, !sel});
        chk("R3 data strobe", {31'd0, dstb_n}, {31'd0, sel});
        chk("R3 bus byte", {24'd0, pbus_q}, {24'd0, d});
        chk("R3 bus enable", {31'd0, pbus_oe}, {31'd0, exp_oe});
        chk("R3 write line", {31'd0, pwr_n}, {31'd0, exp_wr_n});
        chk("R1 stalled at strobe", {31'd0, host_rdy}, 32'd0);
        repeat (ack_dly) @(negedge clk);
        chk("R4 strobe held before ack", {31'd0, dstb_n & astb_n}, 32'd0);
        dev_wait_n = 1'b1;
        c = 0;
        forever begin
            @(negedge clk);
            c++;
            if ((dstb_n && astb_n) || c > 10) break;
        end
        chk("R4 strobe release latency", c, 32'd3);
        chk("R4 write line after strobe", {31'd0, pwr_n}, {31'd0, exp_wr_n});
        chk("R4 still stalled", {31'd0, host_rdy}, 32'd0);
        @(negedge clk);
        chk("R4 write line released", {31'd0, pwr_n}, {31'd0, end2_wr_n});
        chk("R4 stalled one more", {31'd0, host_rdy}, 32'd0);
        @(negedge clk);
        chk("R4 ready after release", {31'd0, host_rdy}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R10 no repeat ready", {31'd0, host_rdy}, 32'd1);
        chk("R10 no repeat strobe", {30'd0, dstb_n, astb_n}, 32'd3);
        chk("R6 no flag on good cycle", {31'd0, tmo_flag}, 32'd0);
        wr_req = 1'b0;
        @(negedge clk);
    endtask

    // A cycle whose peripheral never acknowledges.
    task automatic do_timeout(input bit pre_low);
        int n;
        dev_wait_n = pre_low ? 1'b0 : 1'b1;
        repeat (3) @(negedge clk);
        wr_sel_addr = pre_low;
        wr_data     = 8'h5A;
        wr_req      = 1'b1;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (host_rdy || n > 100) break;
        end
        chk("R5 abort cycle", n, TMO + 1);
        chk("R5 strobes released", {30'd0, dstb_n, astb_n}, 32'd3);
        chk("R6 flag set", {31'd0, tmo_flag}, 32'd1);
        wr_req = 1'b0;
        dev_wait_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R6 flag sticky", {31'd0, tmo_flag}, 32'd1);
        tmo_clr = 1'b1;
        @(negedge clk);
        tmo_clr = 1'b0;
        chk("R6 flag cleared", {31'd0, tmo_flag}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        vectors++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset ready", {31'd0, host_rdy}, 32'd1);
        chk("R9 reset strobes", {30'd0, dstb_n, astb_n}, 32'd3);
        chk("R9 reset write line", {31'd0, pwr_n}, 32'd1);
        chk("R6 reset flag", {31'd0, tmo_flag}, 32'd0);

        // R9: idle pins follow the control and data registers
        for (int p = 0; p < 16; p++) begin
            {ctl_strobe, ctl_feed, ctl_init, ctl_dir} = 4'(p);
            spp_dat = 8'(p * 37 + 3);
            @(negedge clk);
            chk("R9 lp_strobe", {31'd0, lp_strobe}, {31'd0, p[3]});
            chk("R9 lp_feed", {31'd0, lp_feed}, {31'd0, p[2]});
            chk("R9 lp_init", {31'd0, lp_init}, {31'd0, p[1]});
            chk("R9 bus enable", {31'd0, pbus_oe}, {31'd0, !p[0]});
            chk("R9 bus value", {24'd0, pbus_q}, {24'd0, 8'(p * 37 + 3)});
            chk("R9 write line", {31'd0, pwr_n}, 32'd1);
        end
        {ctl_strobe, ctl_feed, ctl_init, ctl_dir} = 4'b0000;

        // R2 R3 R4 R10: every byte through both strobes
        for (int s = 0; s < 2; s++) begin
            for (int d = 0; d < 256; d++) begin
                do_write(s[0], 8'(d), d[1], d % 2, 1'b1, 1'b0);
            end
        end

        // R8: direction bit set, no write performed
        ctl_dir = 1'b1;
        do_write(1'b0, 8'hC3, 1'b1, 1, 1'b0, 1'b1);
        do_write(1'b1, 8'h3C, 1'b0, 0, 1'b0, 1'b1);
        chk("R8 no flag", {31'd0, tmo_flag}, 32'd0);

        // R7: strobe bit forces write mode
        ctl_strobe = 1'b1;
        do_write(1'b0, 8'h99, 1'b1, 0, 1'b1, 1'b0);
        chk("R7 idle after override oe", {31'd0, pbus_oe}, 32'd0);
        chk("R7 idle after override wr", {31'd0, pwr_n}, 32'd1);
        ctl_strobe = 1'b0;
        ctl_dir    = 1'b0;

        // R5 R6: abort before strobe and during strobe
        do_timeout(1'b0);
        do_timeout(1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule